// File: doc/BRIEF.md
# Adaptive On-Time Switching Sequencer

This block is the digital core of a constant-on-time synchronous buck loop. It takes comparator flags that are already digitized: output below reference, valley overcurrent, inductor zero crossing and negative overcurrent. It also takes a mode select and a programmed on-time count. From these it drives the high-side and low-side gate enables. There is no oscillator. A switching cycle starts whenever feedback asks for energy and the valley current allows it. The high-side pulse then runs for the programmed number of clocks. The low-side switch conducts for the rest of the cycle, and the block puts a gap with both switches off at every hand-over between them.

The block has two running modes. In light-load skip mode, it emulates a diode: the low-side switch opens at zero current and the stage rests until feedback asks again. The high-side pulse keeps the same length in this mode. In forced continuous mode, zero crossings are ignored. If the inductor current goes too far negative, the low-side switch opens for a retry interval and then closes again. This repeats for as long as the condition lasts. A fault input or the disabled mode drops both gates at once and returns the sequencer to rest.

The parameters are `TON_W` (width of the on-time count), `DEAD_CYC` (dead-time length in clocks, at least 1) and `RETRY_CYC` (low-side retry interval in clocks, at least `DEAD_CYC`). At 200 MHz, 80 clocks make the 400 ns retry interval.

Top module: `cot_switch_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `hs_on` and `ls_on` are both low and the sequencer is at rest.
- R2: `hs_on` and `ls_on` are never high in the same cycle.
- R3: A new cycle is requested only when `fb_low` is 1 and `ocl_valley` is 0. While `ocl_valley` is 1, no high-side pulse starts and a conducting low-side switch stays on.
- R4: Each high-side pulse lasts exactly the number of clocks held in `ton_cycles`. A count of 0 gives a one-clock pulse.
- R5: At least `DEAD_CYC` cycles with both enables low come before every rising edge of `hs_on` and of `ls_on`. Exactly `DEAD_CYC` such cycles separate the end of a high-side pulse from the low-side turn-on.
- R6: After each high-side pulse and its dead time, `ls_on` goes high and stays high until one of the events in R7, R9, R10 or R11 occurs.
- R7: In skip mode (`mode` = 2'b01), a `zero_cross` seen while `ls_on` is high, with no cycle request, turns both switches off on the next cycle. They stay off until a cycle request arrives. `neg_ocl` has no effect in this mode.
- R8: In forced continuous mode (`mode` = 2'b10), `zero_cross` has no effect and `ls_on` stays high.
- R9: In forced continuous mode, `neg_ocl` seen while `ls_on` is high, with no cycle request, drops `ls_on` on the next cycle. `ls_on` then returns after exactly `RETRY_CYC` cycles off. While the flag persists, this repeats.
- R10: A cycle request seen while the low-side switch is on, or during the retry interval, turns the low-side switch off. A high-side pulse follows after exactly `DEAD_CYC` cycles with both switches off.
- R11: When `fault_off` is 1, or `mode` is 2'b00 or 2'b11, both enables go low on the next cycle and stay low. After that, the sequencer waits at rest for a cycle request.
- R12: `ton_cycles` is sampled only when a high-side pulse begins. Changing it during the pulse has no effect on that pulse.
- R13: In skip mode, the high-side pulse has the same length as in forced continuous mode for the same `ton_cycles`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | 01 skip, 10 forced continuous, 00/11 disabled |
| fault_off | input | 1 | Forces both gates off while high |
| fb_low | input | 1 | Output below reference |
| ocl_valley | input | 1 | Valley current above limit |
| zero_cross | input | 1 | Inductor current reached zero |
| neg_ocl | input | 1 | Inductor current beyond negative limit |
| ton_cycles | input | TON_W | High-side on-time in clocks |
| hs_on | output | 1 | High-side gate enable |
| ls_on | output | 1 | Low-side gate enable |

## Verification
The assertions assume that every flag and the mode are synchronous to `clk`, and that `RETRY_CYC` is not shorter than `DEAD_CYC`. Without that second condition, a retry turn-on could follow a shorter gap than the dead time. The bench keeps to these assumptions: it changes inputs only on falling edges and uses the default parameters. The flag patterns are driven as single-cycle pulses or as sustained levels. The bench also changes the mode and the on-time count in the middle of a sequence, including during a pulse.

// File: rtl/cot_switch_seq.sv
module cot_switch_seq #(
  parameter int TON_W     = 10,
  parameter int DEAD_CYC  = 2,
  parameter int RETRY_CYC = 80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             fault_off,
  input  logic             fb_low,
  input  logic             ocl_valley,
  input  logic             zero_cross,
  input  logic             neg_ocl,
  input  logic [TON_W-1:0] ton_cycles,
  output logic             hs_on,
  output logic             ls_on
);
  localparam logic [1:0] MODE_SKIP = 2'b01;
  localparam logic [1:0] MODE_PWM  = 2'b10;
  localparam int FIX_MAX = (DEAD_CYC > RETRY_CYC) ? DEAD_CYC : RETRY_CYC;
  localparam int FIX_W   = $clog2(FIX_MAX + 1);
  localparam int CW      = (FIX_W > TON_W) ? FIX_W : TON_W;
  localparam int GW      = $clog2(DEAD_CYC + 2);

  typedef enum logic [2:0] {S_IDLE, S_DT_HI, S_HIGH, S_DT_LO, S_LOW, S_NEG} state_t;

  state_t        state, state_n;
  logic [CW-1:0] cnt, cnt_n;

  wire run     = (mode == MODE_SKIP || mode == MODE_PWM) && !fault_off;
  wire start   = fb_low && !ocl_valley;
  wire skip    = (mode == MODE_SKIP);
  wire pwm     = (mode == MODE_PWM);
  wire expired = (cnt == '0);

  wire [CW-1:0] dead_ld  = CW'(DEAD_CYC - 1);
  wire [CW-1:0] retry_ld = CW'(RETRY_CYC - 1);
  wire [CW-1:0] ton_ld   = (ton_cycles == '0) ? '0 : CW'(ton_cycles) - CW'(1);
  wire [CW-1:0] cnt_dec  = cnt - CW'(1);

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    case (state)
      S_IDLE:
        if (start) begin state_n = S_DT_HI; cnt_n = dead_ld; end
      S_DT_HI:
        if (expired) begin state_n = S_HIGH; cnt_n = ton_ld; end
        else cnt_n = cnt_dec;
      S_HIGH:
        if (expired) begin state_n = S_DT_LO; cnt_n = dead_ld; end
        else cnt_n = cnt_dec;
      S_DT_LO:
        if (expired) state_n = S_LOW;
        else cnt_n = cnt_dec;
      S_LOW:
        if (start) begin state_n = S_DT_HI; cnt_n = dead_ld; end
        else if (skip && zero_cross) state_n = S_IDLE;
        else if (pwm && neg_ocl) begin state_n = S_NEG; cnt_n = retry_ld; end
      S_NEG:
        if (start) begin state_n = S_DT_HI; cnt_n = dead_ld; end
        else if (expired) state_n = S_LOW;
        else cnt_n = cnt_dec;
      default: state_n = S_IDLE;
    endcase
    if (!run) begin
      state_n = S_IDLE;
      cnt_n   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      state <= state_n;
      cnt   <= cnt_n;
    end

  assign hs_on = (state == S_HIGH);
  assign ls_on = (state == S_LOW);

  logic [GW-1:0] off_run;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) off_run <= '0;
    else if (hs_on || ls_on) off_run <= '0;
    else if (off_run < GW'(DEAD_CYC)) off_run <= off_run + GW'(1);

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));
  a_r5_dead_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> off_run >= GW'(DEAD_CYC));
  a_r5_dead_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> off_run >= GW'(DEAD_CYC));
  a_r3_ocl_holds_low: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on && run && ocl_valley && !(skip && zero_cross) && !(pwm && neg_ocl) |=> ls_on);
  a_r7_skip_release: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on && run && skip && zero_cross && !start |=> !ls_on && !hs_on);
  a_r8_pwm_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on && run && pwm && zero_cross && !neg_ocl && !start |=> ls_on);
  a_r9_neg_drops_low: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on && run && pwm && neg_ocl && !start |=> !ls_on && !hs_on);
  a_r10_request_drops_low: assert property (@(posedge clk) disable iff (!rst_n)
    ls_on && run && start |=> !ls_on && !hs_on);
  a_r11_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !hs_on && !ls_on);
endmodule

// File: tb/cot_switch_seq_tb.sv
`timescale 1ns/1ps
module cot_switch_seq_tb;
  localparam int TON_W = 10, DEAD = 2, RETRY = 80;
  localparam int P_IDLE = 0, P_DTH = 1, P_HI = 2, P_DTL = 3, P_LO = 4, P_NEG = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b10;
  logic fault_off = 0, fb_low = 0, ocl_valley = 0, zero_cross = 0, neg_ocl = 0;
  logic [TON_W-1:0] ton_cycles = 5;
  logic hs_on, ls_on;

  cot_switch_seq #(.TON_W(TON_W), .DEAD_CYC(DEAD), .RETRY_CYC(RETRY)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .fault_off(fault_off), .fb_low(fb_low),
    .ocl_valley(ocl_valley), .zero_cross(zero_cross), .neg_ocl(neg_ocl),
    .ton_cycles(ton_cycles), .hs_on(hs_on), .ls_on(ls_on));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_ph = P_IDLE, m_rem = 0;
  always @(posedge clk) begin
    bit act, req;
    act = (mode == 2'b01 || mode == 2'b10) && !fault_off;
    req = fb_low && !ocl_valley;
    if (!rst_n || !act) m_ph = P_IDLE;
    else case (m_ph)
      P_IDLE: if (req) begin m_ph = P_DTH; m_rem = DEAD; end
      P_DTH: begin
        m_rem--;
        if (m_rem == 0) begin m_ph = P_HI; m_rem = (ton_cycles == 0) ? 1 : int'(ton_cycles); end
      end
      P_HI: begin m_rem--; if (m_rem == 0) begin m_ph = P_DTL; m_rem = DEAD; end end
      P_DTL: begin m_rem--; if (m_rem == 0) m_ph = P_LO; end
      P_LO:
        if (req) begin m_ph = P_DTH; m_rem = DEAD; end
        else if (mode == 2'b01 && zero_cross) m_ph = P_IDLE;
        else if (mode == 2'b10 && neg_ocl) begin m_ph = P_NEG; m_rem = RETRY; end
      P_NEG:
        if (req) begin m_ph = P_DTH; m_rem = DEAD; end
        else begin m_rem--; if (m_rem == 0) m_ph = P_LO; end
      default: m_ph = P_IDLE;
    endcase
  end

  int hs_run = 0, off_run = 0, last_hs_w = 0, last_hs_gap = 0, last_ls_gap = 0;
  int hs_rises = 0, ls_rises = 0, overlap = 0;
  bit prev_hs = 0, prev_ls = 0;

  function automatic string phase_tag(int ph);
    case (ph)
      P_HI: return "R4";
      P_LO: return "R6";
      P_DTH, P_DTL: return "R5";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      checks++;
      if (hs_on !== (m_ph == P_HI) || ls_on !== (m_ph == P_LO)) begin
        errors++;
        $display("FAIL %s model: actual hs=%0b ls=%0b expected hs=%0b ls=%0b at %0t",
                 phase_tag(m_ph), hs_on, ls_on, m_ph == P_HI, m_ph == P_LO, $time);
      end
      if (hs_on && ls_on) overlap++;
      if (hs_on && !prev_hs) begin last_hs_gap = off_run; hs_rises++; end
      if (ls_on && !prev_ls) begin last_ls_gap = off_run; ls_rises++; end
      if (!hs_on && prev_hs) last_hs_w = hs_run;
      hs_run  = hs_on ? hs_run + 1 : 0;
      off_run = (!hs_on && !ls_on) ? off_run + 1 : 0;
      prev_hs = hs_on;
      prev_ls = ls_on;
    end
  endtask

  task automatic request();
    fb_low = 1; step(1); fb_low = 0;
  endtask

  initial begin
    int r;
    step(3);
    chk("R1 hs in reset", hs_on, 0);
    chk("R1 ls in reset", ls_on, 0);
    rst_n = 1;
    step(1);
    chk("R1 rest after reset", hs_on | ls_on, 0);

    request(); step(20);
    chk("R4 pulse width", last_hs_w, 5);
    chk("R5 gap high to low", last_ls_gap, DEAD);
    chk("R5 gap before high", int'(last_hs_gap >= DEAD), 1);
    chk("R6 low on after pulse", ls_on, 1);
    zero_cross = 1; step(4);
    chk("R8 zero cross ignored", ls_on, 1);
    zero_cross = 0;

    ton_cycles = 3; request(); step(3);
    ton_cycles = 12; step(15);
    chk("R12 count sampled at start", last_hs_w, 3);
    chk("R10 gap from low", last_hs_gap, DEAD);

    ton_cycles = 4; r = hs_rises;
    ocl_valley = 1; fb_low = 1; step(10);
    chk("R3 no pulse under overcurrent", hs_rises, r);
    chk("R3 low held under overcurrent", ls_on, 1);
    ocl_valley = 0; step(1); fb_low = 0; step(15);
    chk("R3 pulse after overcurrent clears", hs_rises, r + 1);
    chk("R4 pulse width 4", last_hs_w, 4);

    neg_ocl = 1; step(1); neg_ocl = 0;
    chk("R9 low dropped", ls_on, 0);
    step(RETRY + 3);
    chk("R9 retry interval", last_ls_gap, RETRY);
    chk("R9 low back on", ls_on, 1);
    r = ls_rises;
    neg_ocl = 1; step(3 * (RETRY + 1)); neg_ocl = 0;
    chk("R9 repeated retries", int'(ls_rises - r >= 2), 1);
    step(RETRY + 2);
    r = hs_rises;
    neg_ocl = 1; step(1); neg_ocl = 0; step(5);
    request(); step(12);
    chk("R10 request during retry", hs_rises, r + 1);
    chk("R10 gap after retry", int'(last_hs_gap >= DEAD), 1);

    mode = 2'b01; step(2);
    zero_cross = 1; step(1); zero_cross = 0;
    chk("R7 both off at zero", hs_on | ls_on, 0);
    step(10);
    chk("R7 rest until request", hs_on | ls_on, 0);
    request(); step(15);
    chk("R13 skip pulse width", last_hs_w, 4);
    neg_ocl = 1; step(5);
    chk("R7 negative flag ignored", ls_on, 1);
    neg_ocl = 0;

    ton_cycles = 0; request(); step(12);
    chk("R4 zero count one clock", last_hs_w, 1);

    mode = 2'b10; ton_cycles = 20; request(); step(4);
    chk("R4 mid pulse", hs_on, 1);
    fault_off = 1; step(1);
    chk("R11 fault drops gates", hs_on | ls_on, 0);
    step(3); fault_off = 0; step(5);
    chk("R11 rest after fault", hs_on | ls_on, 0);
    ton_cycles = 3; request(); step(12);
    mode = 2'b00; step(1);
    chk("R11 disabled mode", hs_on | ls_on, 0);
    mode = 2'b11; fb_low = 1; step(5);
    chk("R11 mode 11 disabled", hs_on | ls_on, 0);
    fb_low = 0;
    chk("R2 overlap cycles", overlap, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule